// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital controller of a successive-approximation converter. It derives a slower converter tick from the system clock by a selectable ratio. A conversion can be started by software, by a falling edge on an external pin, or by a pulse from a timer. The block then walks a trial code from the most significant bit down, one decision per tick, and keeps or drops each bit according to a single comparator bit. At the end it latches the code as the result and raises a one-cycle done pulse.

The total length of a conversion is fixed by two settings: the resolution (8 or 10 bits) and whether sample-and-hold is enabled. Each conversion starts with a sampling phase. The bit decisions fill the remaining ticks of the budget. In one-shot operation the start bit drops by itself when the conversion ends. In repeat operation conversions follow one another back to back until software clears the start bit. A new trigger that arrives while a conversion runs throws away the running conversion and starts a fresh one.

Top module: `adc_sar_sequencer`

## Requirements
- R1: `div_sel` picks the tick ratio D: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 6, and 5, 6 or 7 give 8. The divider restarts at each launch, so a conversion spans exactly budget×D clock cycles. For a launch sampled at edge E, `done` is high after edge E + budget×D.
- R2: The budget in ticks depends on the settings. With `sh_enable`=0 it is 49 at 8 bits (`res_10b`=0) and 59 at 10 bits. With `sh_enable`=1 it is 28 at 8 bits and 33 at 10 bits.
- R3: Bits are decided MSB first, one per tick, in the last N ticks of the budget (N = 8 or 10). `cmp_in`=1 means the input is at or above `dac_code`, and the bit under test is kept. An 8-bit result sits in `result[7:0]` with `result[9:8]` zero, so an out-of-range input saturates at 0x0FF.
- R4: With `trig_mode`=00 (software), a `start_set` pulse sets the start bit and launches at the same edge. Code 11 behaves like 00.
- R5: With `trig_mode`=01 (external), `start_set` only arms the block. The falling edge of `ext_trig_n` passes a two-flop synchronizer. When the pin falls before edge E1, the launch happens at edge E1+2. Falling edges that occur while the block is not armed never launch.
- R6: With `trig_mode`=10 (timer), `start_set` only arms the block. A `tmr_event` pulse launches only while the block is armed.
- R7: A trigger that arrives while a conversion runs restarts it. No done is produced for the aborted conversion, and the next `done` follows the new launch by budget×D cycles.
- R8: At the end of a conversion, `result` updates and `done` goes high for exactly one cycle, both after the same edge. In one-shot mode (`repeat_en`=0), `armed` is low from that same edge.
- R9: With `repeat_en`=1, a new conversion begins at the edge that ends the previous one, and `armed` stays high. A `start_clr` pulse clears `armed` and `busy` at the next edge, aborts any conversion without a done pulse, and leaves `result` unchanged.
- R10: After reset, `busy`, `armed`, `done`, `result` and `dac_code` are all zero.
- R11: `dac_code` is zero whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Converter tick ratio select |
| res_10b | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_enable | input | 1 | Sample-and-hold enable (selects shorter budget) |
| trig_mode | input | 2 | 00 software, 01 external falling edge, 10 timer, 11 software |
| repeat_en | input | 1 | 1 = repeat operation, 0 = one-shot |
| start_set | input | 1 | Pulse: set start bit (and launch in software mode) |
| start_clr | input | 1 | Pulse: clear start bit and abort |
| ext_trig_n | input | 1 | External trigger pin, active on falling edge |
| tmr_event | input | 1 | Timer event pulse |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| dac_code | output | 10 | Current trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| armed | output | 1 | Start bit |
| done | output | 1 | One-cycle pulse at conversion end |
| result | output | 10 | Last completed conversion code |

## Verification
The bench counts clock edges from the edge that samples a trigger. It expects `done` and the new `result` after edge budget×D for software and timer launches, and after edge budget×D + 2 for an external pin edge, because of the two synchronizer flops. `armed` and `busy` are due one edge after `start_set` or `start_clr`. Inputs are driven on the falling clock edge and every output is read there, half a cycle after the rising edge that produced it, so each count lands on a single well-defined edge. The case where a conversion is ignored or aborted is checked by watching `done` and `result` over a window longer than a full conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    TRG_SW  = 2'b00,
    TRG_EXT = 2'b01,
    TRG_TMR = 2'b10,
    TRG_RSV = 2'b11
  } trig_mode_e;

  localparam int CYC_8_PLAIN  = 49;
  localparam int CYC_10_PLAIN = 59;
  localparam int CYC_8_SH     = 28;
  localparam int CYC_10_SH    = 33;

  function automatic logic [3:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [6:0] conv_budget(input logic wide, input logic sh);
    case ({wide, sh})
      2'b00:   return 7'(CYC_8_PLAIN);
      2'b10:   return 7'(CYC_10_PLAIN);
      2'b01:   return 7'(CYC_8_SH);
      default: return 7'(CYC_10_SH);
    endcase
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W  = 3,
  parameter int DCNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import adc_seq_pkg::*;

  logic [DCNT_W-1:0] dcnt_q;
  logic [3:0]        ratio;

  assign ratio = div_ratio(3'(sel));
  assign tick  = en && (dcnt_q == DCNT_W'(ratio - 4'd1));

  always_ff @(posedge clk) begin
    if (rst || clr || !en || tick) dcnt_q <= '0;
    else                           dcnt_q <= dcnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_trig_unit.sv
module adc_trig_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       armed,
  input  logic       sw_set,
  input  logic       ext_n,
  input  logic       tmr_evt,
  output logic       fire
);
  import adc_seq_pkg::*;

  logic sync1_q, sync2_q, ref_q;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      ref_q   <= 1'b1;
    end else begin
      sync1_q <= ext_n;
      sync2_q <= sync1_q;
      ref_q   <= sync2_q;
    end
  end

  assign fall = ref_q & ~sync2_q;

  always_comb begin
    case (trig_mode_e'(mode))
      TRG_EXT: fire = armed & fall;
      TRG_TMR: fire = armed & tmr_evt;
      default: fire = sw_set;
    endcase
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  parameter int CYC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             abort,
  input  logic             tick,
  input  logic             res10,
  input  logic             sh_en,
  input  logic             cmp_in,
  input  logic             keep_going,
  output logic             busy,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             finish
);
  import adc_seq_pkg::*;

  localparam logic [RES_W-1:0] FIRST_W = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] FIRST_N = {{(RES_W-LO_W){1'b0}}, 1'b1, {(LO_W-1){1'b0}}};

  logic             busy_q, res_q, sh_q, done_q;
  logic [CYC_W-1:0] cyc_q, total, nbits, samp, bidx;
  logic [RES_W-1:0] trial_q, result_q, next_trial;
  logic             decide, last;

  assign total  = CYC_W'(conv_budget(res_q, sh_q));
  assign nbits  = res_q ? CYC_W'(RES_W) : CYC_W'(LO_W);
  assign samp   = total - nbits;
  assign decide = (cyc_q >= samp);
  assign bidx   = nbits - CYC_W'(1) - (cyc_q - samp);
  assign last   = (cyc_q == total - CYC_W'(1));
  assign finish = busy_q && tick && last && !launch && !abort;

  always_comb begin
    next_trial = trial_q;
    if (decide) begin
      for (int i = 0; i < RES_W; i++) begin
        if (CYC_W'(i) == bidx)          next_trial[i] = trial_q[i] & cmp_in;
        else if (CYC_W'(i + 1) == bidx) next_trial[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      res_q    <= 1'b0;
      sh_q     <= 1'b0;
      done_q   <= 1'b0;
      cyc_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q  <= 1'b0;
        cyc_q   <= '0;
        trial_q <= '0;
      end else if (launch) begin
        busy_q  <= 1'b1;
        res_q   <= res10;
        sh_q    <= sh_en;
        cyc_q   <= '0;
        trial_q <= res10 ? FIRST_W : FIRST_N;
      end else if (busy_q && tick) begin
        if (last) begin
          result_q <= next_trial;
          done_q   <= 1'b1;
          cyc_q    <= '0;
          if (keep_going) begin
            trial_q <= res_q ? FIRST_W : FIRST_N;
          end else begin
            busy_q  <= 1'b0;
            trial_q <= '0;
          end
        end else begin
          trial_q <= next_trial;
          cyc_q   <= cyc_q + 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign trial  = trial_q;
  assign result = result_q;
  assign done   = done_q;
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             res_10b,
  input  logic             sh_enable,
  input  logic [1:0]       trig_mode,
  input  logic             repeat_en,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic             ext_trig_n,
  input  logic             tmr_event,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic             armed,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int CYC_W  = 7;
  localparam int DCNT_W = 3;

  logic start_q, fire, launch, tick, finish, keep_going;

  assign launch     = fire & ~start_clr;
  assign keep_going = repeat_en & start_q;

  adc_trig_unit u_trig (
    .clk     (clk),
    .rst     (rst),
    .mode    (trig_mode),
    .armed   (start_q),
    .sw_set  (start_set),
    .ext_n   (ext_trig_n),
    .tmr_evt (tmr_event),
    .fire    (fire)
  );

  adc_clk_div #(.SEL_W(SEL_W), .DCNT_W(DCNT_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .clr  (launch),
    .sel  (div_sel),
    .tick (tick)
  );

  adc_sar_core #(.RES_W(RES_W), .LO_W(LO_W), .CYC_W(CYC_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .abort      (start_clr),
    .tick       (tick),
    .res10      (res_10b),
    .sh_en      (sh_enable),
    .cmp_in     (cmp_in),
    .keep_going (keep_going),
    .busy       (busy),
    .trial      (dac_code),
    .result     (result),
    .done       (done),
    .finish     (finish)
  );

  always_ff @(posedge clk) begin
    if (rst)                         start_q <= 1'b0;
    else if (start_clr)              start_q <= 1'b0;
    else if (start_set)              start_q <= 1'b1;
    else if (finish && !repeat_en)   start_q <= 1'b0;
  end

  assign armed = start_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             armed,
  input logic             done,
  input logic             start_set,
  input logic             start_clr,
  input logic             repeat_en,
  input logic [RES_W-1:0] dac_code
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(repeat_en) && !$past(start_set)) |-> !armed);

  // R9
  clear_stop_chk: assert property (@(posedge clk) disable iff (rst)
    start_clr |=> (!busy && !armed && !done));

  // R11
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_code == '0));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

bind adc_sar_sequencer adc_seq_chk #(.RES_W(RES_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .armed     (armed),
  .done      (done),
  .start_set (start_set),
  .start_clr (start_clr),
  .repeat_en (repeat_en),
  .dac_code  (dac_code)
);

// File: tb/test_adc_sar_sequencer.sv
`timescale 1ns/1ps
module test_adc_sar_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic       res_10b = 1'b0, sh_enable = 1'b0, repeat_en = 1'b0;
  logic [1:0] trig_mode = 2'b00;
  logic       start_set = 1'b0, start_clr = 1'b0;
  logic       ext_trig_n = 1'b1, tmr_event = 1'b0;
  logic [9:0] target = 10'd0;
  logic       cmp_in;
  logic [9:0] dac_code, result;
  logic       busy, armed, done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign cmp_in = (dac_code <= target);

  adc_sar_sequencer i_adc_sar_sequencer (
    .clk(clk), .rst(rst), .div_sel(div_sel), .res_10b(res_10b),
    .sh_enable(sh_enable), .trig_mode(trig_mode), .repeat_en(repeat_en),
    .start_set(start_set), .start_clr(start_clr), .ext_trig_n(ext_trig_n),
    .tmr_event(tmr_event), .cmp_in(cmp_in), .dac_code(dac_code),
    .busy(busy), .armed(armed), .done(done), .result(result)
  );

  // {div_sel, res_10b, sh_enable, target, expected result, expected cycles}
  localparam int NV = 8;
  localparam logic [34:0] VECS [NV] = '{
    {3'd0, 1'b0, 1'b0, 10'h0A5, 10'h0A5, 10'd49},
    {3'd1, 1'b1, 1'b0, 10'h2C3, 10'h2C3, 10'd118},
    {3'd2, 1'b0, 1'b1, 10'h0FF, 10'h0FF, 10'd84},
    {3'd3, 1'b1, 1'b1, 10'h000, 10'h000, 10'd132},
    {3'd4, 1'b1, 1'b0, 10'h3FF, 10'h3FF, 10'd354},
    {3'd5, 1'b0, 1'b1, 10'h03C, 10'h03C, 10'd224},
    {3'd0, 1'b1, 1'b1, 10'h155, 10'h155, 10'd33},
    {3'd7, 1'b0, 1'b0, 10'h001, 10'h001, 10'd392}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    start_set = 1'b0;
    start_clr = 1'b0;
    tmr_event = 1'b0;
  endtask

  // Counts rising edges until done is seen at a falling edge.
  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      clear_pulses();
    end while (!done && n < 5000);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
      clear_pulses();
    end
  endtask

  task automatic count_done(input int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
      clear_pulses();
      if (done) seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, seen;
    logic [9:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 armed", armed, 0);
    check("R10 done", done, 0);
    check("R10 result", result, 0);
    check("R10 dac_code", dac_code, 0);

    for (int v = 0; v < NV; v++) begin
      div_sel   = VECS[v][34:32];
      res_10b   = VECS[v][31];
      sh_enable = VECS[v][30];
      target    = VECS[v][29:20];
      trig_mode = 2'b00;
      repeat_en = 1'b0;
      start_set = 1'b1;
      wait_done(n);
      // R1 R2 R4: done after edge E + budget*D
      check("R1 R2 R4 latency", n, int'(VECS[v][9:0]) + 1);
      check("R3 result", result, int'(VECS[v][19:10]));
      check("R8 one-shot disarm", armed, 0);
      @(posedge clk); @(negedge clk);
      check("R8 done width", done, 0);
      check("R11 idle code", dac_code, 0);
    end

    // R3 out-of-range input at 8 bits saturates, upper bits zero
    div_sel = 3'd0; res_10b = 1'b0; sh_enable = 1'b0; target = 10'h3A7;
    start_set = 1'b1;
    wait_done(n);
    check("R3 saturate", result, 10'h0FF);
    check("R3 upper zero", int'(result[9:8]), 0);

    // R5 external trigger
    trig_mode = 2'b01; div_sel = 3'd1; res_10b = 1'b0; sh_enable = 1'b1;
    target = 10'h07E;
    ext_trig_n = 1'b0;
    idle(8);
    check("R5 edge while disarmed", busy, 0);
    ext_trig_n = 1'b1;
    idle(4);
    start_set = 1'b1;
    idle(1);
    check("R5 armed", armed, 1);
    idle(8);
    check("R5 arm does not launch", busy, 0);
    ext_trig_n = 1'b0;
    wait_done(n);
    check("R5 latency", n, 28 * 2 + 3);
    check("R5 result", result, 10'h07E);
    ext_trig_n = 1'b1;
    idle(4);

    // R6 timer trigger
    trig_mode = 2'b10; div_sel = 3'd0; res_10b = 1'b1; sh_enable = 1'b0;
    target = 10'h1E4;
    tmr_event = 1'b1;
    idle(6);
    check("R6 event while disarmed", busy, 0);
    start_set = 1'b1;
    idle(6);
    check("R6 arm does not launch", busy, 0);
    tmr_event = 1'b1;
    wait_done(n);
    check("R6 latency", n, 59 + 1);
    check("R6 result", result, 10'h1E4);

    // R7 retrigger restarts the conversion
    target = 10'h2A1;
    start_set = 1'b1;
    idle(2);
    tmr_event = 1'b1;
    idle(20);
    check("R7 running", busy, 1);
    tmr_event = 1'b1;
    wait_done(n);
    check("R7 latency from retrigger", n, 59 + 1);
    check("R7 result", result, 10'h2A1);

    // R9 repeat operation
    trig_mode = 2'b00; repeat_en = 1'b1; div_sel = 3'd0;
    res_10b = 1'b0; sh_enable = 1'b1; target = 10'h05A;
    start_set = 1'b1;
    wait_done(n);
    check("R9 first latency", n, 28 + 1);
    check("R9 first result", result, 10'h05A);
    target = 10'h0C3;
    wait_done(n);
    check("R9 back-to-back", n, 28);
    check("R9 result", result, 10'h0C3);
    check("R9 stays armed", armed, 1);
    idle(5);
    start_clr = 1'b1;
    idle(1);
    check("R9 clear busy", busy, 0);
    check("R9 clear armed", armed, 0);
    count_done(80, seen);
    check("R9 no done after clear", seen, 0);

    // R9 abort of a one-shot conversion leaves result
    repeat_en = 1'b0; keep = result; target = 10'h011;
    start_set = 1'b1;
    idle(10);
    start_clr = 1'b1;
    count_done(80, seen);
    check("R9 abort no done", seen, 0);
    check("R9 abort keeps result", result, int'(keep));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule